// File: doc/BRIEF.md
# Dual-Bank Multi-Channel Sample Packer

This block sits behind a multi-channel digitizer front end that presents two time samples per channel on every clock. It gathers three consecutive clocks into one group and splits the group by sample parity. Samples that arrive in the first position of each clock are sent to bank 0, and samples in the second position are sent to bank 1. Each bank therefore gets one wide memory word per group, holding three samples for each channel. The two words leave together with one shared ring-buffer address, and a new pair is issued every third clock with no gaps.

Each memory word is wider than its payload. The unused upper bits are driven to zero. The write side must keep pace with the digitizer, so a bank that is not ready when its word is due does not stall the block. The word is counted as lost: a sticky per-bank overflow flag is set and a saturating lost-word counter is incremented.

Sequencing is handled by a three-state phase machine. The states are `PH_SLOT0`, `PH_SLOT1` and `PH_SLOT2`, and one state is visited per clock. Its transitions are named `T_ADV01` (PH_SLOT0 to PH_SLOT1), `T_ADV12` (PH_SLOT1 to PH_SLOT2) and `T_WRAP` (PH_SLOT2 to PH_SLOT0, which also commits the group). The active-low reset forces the machine to `PH_SLOT0` from any state.

Top module: `dual_bank_sample_packer`

## Requirements
- R1: Input lane layout: bits `[k*14 +: 14]` of `in_samples` for k = 0..7 carry the even sample of channel k, and bits `[(8+k)*14 +: 14]` carry the odd sample of channel k.
- R2: In bank 0's word, the even sample of channel c taken on clock s of the group (s = 0, 1, 2) sits at bits `[(s*8+c)*14 +: 14]`.
- R3: Bank 1's word uses the same slot-major layout as R2, filled from the odd samples.
- R4: Bits 383..336 of both bank words are zero whenever the word is valid.
- R5: `bank0_valid` and `bank1_valid` are always equal. After reset is released, they first go high for one cycle after the third rising edge. After that they go high for one cycle in every three, and never miss a group.
- R6: `wr_addr` is 0 for the first word after reset and rises by one for each later word. It wraps from 2^ADDR_W-1 back to 0 and is shared by both banks.
- R7: While `rst_n` is low, the valids are low, the address is 0, both overflow flags are clear and `lost_words` is 0. A reset in the middle of a group discards the partial group, and collection restarts in `PH_SLOT0`.
- R8: If a bank's ready input is low in a cycle where its valid is high, that bank's overflow flag is set from the next edge onward. The flag stays set until reset.
- R9: `lost_words` increases at the edge after each valid cycle by the number of banks that were not ready (0, 1 or 2). It saturates at 2^CNT_W-1.
- R10: The ready inputs have no effect on the data, valid timing or address of any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_samples | input | 2*NUM_CH*SAMPLE_W (224) | Even then odd sample of every channel for this clock |
| bank0_ready | input | 1 | Bank 0 can accept a word this cycle |
| bank1_ready | input | 1 | Bank 1 can accept a word this cycle |
| bank0_data | output | WORD_W (384) | Packed even-sample word |
| bank1_data | output | WORD_W (384) | Packed odd-sample word |
| wr_addr | output | ADDR_W (24) | Shared ring-buffer word address |
| bank0_valid | output | 1 | Bank 0 word is being issued |
| bank1_valid | output | 1 | Bank 1 word is being issued |
| bank0_ovf | output | 1 | Sticky: a bank 0 word was lost |
| bank1_ovf | output | 1 | Sticky: a bank 1 word was lost |
| lost_words | output | CNT_W (16) | Saturating count of lost words over both banks |

## Verification
A group's data, valids and address all come from one register stage that loads on the third edge of the group. The bench therefore samples them at the falling edge that follows that edge, and confirms at the two earlier falling edges that the valids are low. The overflow flags and the lost-word count change on the edge after a valid cycle, when the ready inputs are seen. They stay steady until the next valid cycle, so the bench checks them against its own running totals at the next group's sample point. Ready is set in the same half-cycle as the valid being scored.

// File: rtl/packer_pkg.sv
package packer_pkg;

    // Position of the current clock inside a three-clock group.
    typedef enum logic [1:0] {
        PH_SLOT0 = 2'd0,
        PH_SLOT1 = 2'd1,
        PH_SLOT2 = 2'd2
    } phase_e;

    localparam int unsigned GROUP_SLOTS = 3;
    localparam int unsigned NUM_BANKS   = 2;

endpackage

// File: rtl/group_phase_fsm.sv
module group_phase_fsm
    import packer_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e phase_o,
    output logic   commit_o
);

    phase_e state_q;
    phase_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_SLOT0;
        else        state_q <= state_d;
    end

    // Transitions T_ADV01, T_ADV12, T_WRAP
    always_comb begin
        unique case (state_q)
            PH_SLOT0: state_d = PH_SLOT1;
            PH_SLOT1: state_d = PH_SLOT2;
            PH_SLOT2: state_d = PH_SLOT0;
            default:  state_d = PH_SLOT0;
        endcase
    end

    // Outputs
    always_comb begin
        phase_o  = state_q;
        commit_o = 1'b0;
        unique case (state_q)
            PH_SLOT0: commit_o = 1'b0;
            PH_SLOT1: commit_o = 1'b0;
            PH_SLOT2: commit_o = 1'b1;
            default:  commit_o = 1'b0;
        endcase
    end

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PH_SLOT2 |=> state_q == PH_SLOT0) else $error("phase wrap"); // R7
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PH_SLOT0 |=> state_q == PH_SLOT1) else $error("phase step"); // R5

endmodule

// File: rtl/bank_word_packer.sv
module bank_word_packer
    import packer_pkg::*;
#(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned SAMPLE_W = 14,
    parameter int unsigned WORD_W   = 384
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CH*SAMPLE_W-1:0]   lane_i,
    input  phase_e                       phase_i,
    input  logic                         commit_i,
    output logic [WORD_W-1:0]            word_o,
    output logic                         valid_o
);

    localparam int unsigned LANE_W    = NUM_CH * SAMPLE_W;
    localparam int unsigned PAYLOAD_W = LANE_W * GROUP_SLOTS;
    localparam int unsigned HELD      = GROUP_SLOTS - 1;
    localparam int unsigned PAD_W     = WORD_W - PAYLOAD_W;

    logic [LANE_W-1:0]    held_q [HELD];
    logic [PAYLOAD_W-1:0] payload;
    logic [WORD_W-1:0]    word_d;
    logic [WORD_W-1:0]    word_q;
    logic                 valid_q;

    // One holding register per early slot; the last slot goes straight out.
    for (genvar gi = 0; gi < HELD; gi++) begin : g_hold
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      held_q[gi] <= '0;
            else if (phase_i == phase_e'(gi)) held_q[gi] <= lane_i;
        end
    end

    always_comb begin
        for (int i = 0; i < HELD; i++) payload[i*LANE_W +: LANE_W] = held_q[i];
        payload[HELD*LANE_W +: LANE_W] = lane_i;
    end

    if (PAD_W > 0) begin : g_pad
        assign word_d = {{PAD_W{1'b0}}, payload};
    end else begin : g_nopad
        assign word_d = payload[WORD_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= commit_i;
            if (commit_i) word_q <= word_d;
        end
    end

    assign word_o  = word_q;
    assign valid_o = valid_q;

    AST_LAST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> valid_o && word_o[HELD*LANE_W +: LANE_W] == $past(lane_i))
        else $error("last slot"); // R2
    AST_FIRST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        phase_i == PH_SLOT0 |=> ##2 word_o[LANE_W-1:0] == $past(lane_i, 3))
        else $error("first slot"); // R3
    if (PAD_W > 0) begin : g_pad_chk
        AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            valid_o |-> word_o[WORD_W-1:PAYLOAD_W] == '0) else $error("pad"); // R4
    end

endmodule

// File: rtl/ring_address.sv
module ring_address #(
    parameter int unsigned ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] next_q;
    logic [ADDR_W-1:0] addr_q;

    // Power-of-two depth: the natural carry-out gives the wrap to zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_q <= '0;
            addr_q <= '0;
        end else if (advance_i) begin
            addr_q <= next_q;
            next_q <= next_q + 1'b1;
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/overflow_tracker.sv
module overflow_tracker
    import packer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] due_i,
    input  logic [NUM_BANKS-1:0] ready_i,
    output logic [NUM_BANKS-1:0] ovf_o,
    output logic [CNT_W-1:0]     lost_o
);

    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    logic [NUM_BANKS-1:0] miss;
    logic [NUM_BANKS-1:0] ovf_q;
    logic [CNT_W-1:0]     lost_q;
    logic [CNT_W:0]       sum;

    assign miss = due_i & ~ready_i;

    always_comb begin
        sum = {1'b0, lost_q};
        for (int b = 0; b < NUM_BANKS; b++) sum = sum + {{CNT_W{1'b0}}, miss[b]};
        if (sum > CNT_MAX) sum = CNT_MAX;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q  <= '0;
            lost_q <= '0;
        end else begin
            ovf_q  <= ovf_q | miss;
            lost_q <= sum[CNT_W-1:0];
        end
    end

    assign ovf_o  = ovf_q;
    assign lost_o = lost_q;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_o[b] |=> ovf_o[b]) else $error("sticky"); // R8
        AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
            due_i[b] && !ready_i[b] |=> ovf_o[b]) else $error("set"); // R8
    end
    AST_LOST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lost_o >= $past(lost_o)) else $error("monotonic"); // R9

endmodule

// File: rtl/dual_bank_sample_packer.sv
module dual_bank_sample_packer
    import packer_pkg::*;
#(
    parameter int unsigned NUM_CH   = 8,
    parameter int unsigned SAMPLE_W = 14,
    parameter int unsigned WORD_W   = 384,
    parameter int unsigned ADDR_W   = 24,
    parameter int unsigned CNT_W    = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [2*NUM_CH*SAMPLE_W-1:0]    in_samples,
    input  logic                            bank0_ready,
    input  logic                            bank1_ready,
    output logic [WORD_W-1:0]               bank0_data,
    output logic [WORD_W-1:0]               bank1_data,
    output logic [ADDR_W-1:0]               wr_addr,
    output logic                            bank0_valid,
    output logic                            bank1_valid,
    output logic                            bank0_ovf,
    output logic                            bank1_ovf,
    output logic [CNT_W-1:0]                lost_words
);

    localparam int unsigned LANE_W = NUM_CH * SAMPLE_W;
    localparam logic [CNT_W-1:0] LOST_MAX = {CNT_W{1'b1}};

    phase_e               phase;
    logic                 commit;
    logic [WORD_W-1:0]    word   [NUM_BANKS];
    logic [NUM_BANKS-1:0] valid;
    logic [NUM_BANKS-1:0] ready;
    logic [NUM_BANKS-1:0] ovf;

    group_phase_fsm u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_o  (phase),
        .commit_o (commit)
    );

    // Lane b of the input carries sample parity b; it feeds bank b.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_word_packer #(
            .NUM_CH   (NUM_CH),
            .SAMPLE_W (SAMPLE_W),
            .WORD_W   (WORD_W)
        ) u_pack (
            .clk      (clk),
            .rst_n    (rst_n),
            .lane_i   (in_samples[b*LANE_W +: LANE_W]),
            .phase_i  (phase),
            .commit_i (commit),
            .word_o   (word[b]),
            .valid_o  (valid[b])
        );
    end

    ring_address #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (commit),
        .addr_o    (wr_addr)
    );

    assign ready = {bank1_ready, bank0_ready};

    overflow_tracker #(.CNT_W(CNT_W)) u_ovf (
        .clk     (clk),
        .rst_n   (rst_n),
        .due_i   (valid),
        .ready_i (ready),
        .ovf_o   (ovf),
        .lost_o  (lost_words)
    );

    assign bank0_data  = word[0];
    assign bank1_data  = word[1];
    assign bank0_valid = valid[0];
    assign bank1_valid = valid[1];
    assign bank0_ovf   = ovf[0];
    assign bank1_ovf   = ovf[1];

    AST_BANKS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        bank0_valid == bank1_valid) else $error("aligned"); // R5
    AST_VALID_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
        bank0_valid |=> !bank0_valid ##1 !bank0_valid ##1 bank0_valid)
        else $error("cadence"); // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        bank0_valid |=> ##2 (bank0_valid && wr_addr == ADDR_W'($past(wr_addr, 3) + 1'b1)))
        else $error("addr step"); // R6
    AST_LOST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bank0_valid && !bank0_ready && bank1_ready && lost_words != LOST_MAX
        |=> lost_words == $past(lost_words) + 1'b1) else $error("lost"); // R9

endmodule

// File: tb/dual_bank_sample_packer_test.sv
`timescale 1ns/1ps
module dual_bank_sample_packer_test;

    localparam int NCH = 8;
    localparam int SW  = 14;
    localparam int WW  = 384;
    localparam int AW  = 3;
    localparam int CW  = 3;
    localparam int IW  = 2 * NCH * SW;
    localparam int NVEC = 10;

    // {seed[15:0], ready0, ready1}
    localparam logic [17:0] VEC [NVEC] = '{
        {16'h1234, 1'b1, 1'b1}, {16'h0BAD, 1'b0, 1'b1}, {16'hFFFF, 1'b1, 1'b1},
        {16'h0001, 1'b1, 1'b0}, {16'h5A5A, 1'b1, 1'b1}, {16'hA5A5, 1'b1, 1'b1},
        {16'h7777, 1'b0, 1'b0}, {16'h0000, 1'b1, 1'b1}, {16'h3C3C, 1'b1, 1'b1},
        {16'hC0DE, 1'b1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] in_samples = '0;
    logic          bank0_ready = 1'b1;
    logic          bank1_ready = 1'b1;
    logic [WW-1:0] bank0_data, bank1_data;
    logic [AW-1:0] wr_addr;
    logic          bank0_valid, bank1_valid, bank0_ovf, bank1_ovf;
    logic [CW-1:0] lost_words;

    int checks = 0;
    int errors = 0;
    bit exp_ovf0 = 0, exp_ovf1 = 0;
    int exp_lost = 0;

    always #2.5 clk = ~clk;

    dual_bank_sample_packer #(
        .NUM_CH(NCH), .SAMPLE_W(SW), .WORD_W(WW), .ADDR_W(AW), .CNT_W(CW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .in_samples(in_samples),
        .bank0_ready(bank0_ready), .bank1_ready(bank1_ready),
        .bank0_data(bank0_data), .bank1_data(bank1_data), .wr_addr(wr_addr),
        .bank0_valid(bank0_valid), .bank1_valid(bank1_valid),
        .bank0_ovf(bank0_ovf), .bank1_ovf(bank1_ovf), .lost_words(lost_words)
    );

    function automatic logic [SW-1:0] smp(input logic [15:0] seed, input int s, input int k);
        int v;
        v = int'(seed) * 37 + s * 131 + k * 977 + (k * s) * 53;
        return SW'(v);
    endfunction

    // R1: even sample of channel k at [k*14], odd at [(8+k)*14]
    function automatic logic [IW-1:0] lane(input logic [15:0] seed, input int s);
        logic [IW-1:0] l;
        for (int k = 0; k < 2 * NCH; k++) l[k*SW +: SW] = smp(seed, s, k);
        return l;
    endfunction

    function automatic logic [WW-1:0] word(input logic [15:0] seed, input int bank);
        logic [WW-1:0] w;
        w = '0;
        for (int s = 0; s < 3; s++)
            for (int c = 0; c < NCH; c++)
                w[(s*NCH+c)*SW +: SW] = smp(seed, s, bank*NCH + c);
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic check_flags(input string tag);
        chk(bank0_ovf == exp_ovf0, {tag, " R8 bank0_ovf"}, WW'(bank0_ovf), WW'(exp_ovf0));
        chk(bank1_ovf == exp_ovf1, {tag, " R8 bank1_ovf"}, WW'(bank1_ovf), WW'(exp_ovf1));
        chk(int'(lost_words) == exp_lost, {tag, " R9 lost_words"}, WW'(lost_words), WW'(exp_lost));
    endtask

    task automatic run_group(input logic [15:0] seed, input bit r0, input bit r1, input int eaddr);
        logic [WW-1:0] e0, e1;
        for (int s = 0; s < 3; s++) begin
            in_samples = lane(seed, s);
            @(posedge clk);
            @(negedge clk);
            if (s == 0) begin
                bank0_ready = 1'b1;
                bank1_ready = 1'b1;
            end
            if (s < 2)
                chk(!bank0_valid && !bank1_valid, "R5 valid low mid-group",
                    WW'({bank1_valid, bank0_valid}), '0);
        end
        e0 = word(seed, 0);
        e1 = word(seed, 1);
        chk(bank0_valid && bank1_valid, "R5 valid high on group end",
            WW'({bank1_valid, bank0_valid}), WW'(2'b11));
        chk(bank0_data == e0, "R2 R10 bank0 word", bank0_data, e0);
        chk(bank1_data == e1, "R3 R10 bank1 word", bank1_data, e1);
        chk(bank0_data[WW-1:336] == '0 && bank1_data[WW-1:336] == '0, "R4 pad zero",
            WW'(bank0_data[WW-1:336] | bank1_data[WW-1:336]), '0);
        chk(int'(wr_addr) == eaddr, "R6 R10 address", WW'(wr_addr), WW'(eaddr));
        check_flags("group");
        bank0_ready = r0;
        bank1_ready = r1;
        if (!r0) exp_ovf0 = 1;
        if (!r1) exp_ovf1 = 1;
        exp_lost = exp_lost + (r0 ? 0 : 1) + (r1 ? 0 : 1);
        if (exp_lost > (1 << CW) - 1) exp_lost = (1 << CW) - 1;
    endtask

    bit done = 0;
    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int g;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(!bank0_valid && !bank1_valid && wr_addr == '0, "R7 reset outputs",
            WW'({wr_addr, bank1_valid, bank0_valid}), '0);
        check_flags("R7 reset");
        rst_n = 1'b1;

        // Table walk; AW=3 so the address wraps after 8 groups (R6)
        g = 0;
        for (int i = 0; i < NVEC; i++) begin
            run_group(VEC[i][17:2], VEC[i][1], VEC[i][0], g % (1 << AW));
            g++;
        end

        // Saturation of the lost-word counter (R9)
        for (int i = 0; i < 3; i++) begin
            run_group(16'h4321 + 16'(i), 1'b0, 1'b0, g % (1 << AW));
            g++;
        end
        run_group(16'h9999, 1'b1, 1'b1, g % (1 << AW));
        g++;
        chk(lost_words == 3'd7, "R9 saturated", WW'(lost_words), WW'(7));

        // R7: reset in the middle of a group discards it
        in_samples = lane(16'hDEAD, 0);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        exp_ovf0 = 0; exp_ovf1 = 0; exp_lost = 0;
        @(negedge clk);
        chk(!bank0_valid && wr_addr == '0, "R7 mid-group reset",
            WW'({wr_addr, bank0_valid}), '0);
        check_flags("R7 mid reset");
        rst_n = 1'b1;
        run_group(16'h2468, 1'b1, 1'b1, 0);
        run_group(16'h1357, 1'b1, 1'b1, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule